// File: doc/BRIEF.md
# Symmetric FIR Filter with Approximate Adders

This block filters one channel of sampled biological signal data with a streaming linear-phase FIR filter of order eight. Each signed input sample is accepted on a strobe into a nine-stage delay line. The two samples at each mirrored pair of positions are summed first. Each of the four pair sums, and the unpaired centre sample, is multiplied by its constant coefficient. The five products are then reduced to one 35-bit output sample. The filter takes a new sample on every clock if needed, which is far above the few-kHz per-channel rate it is meant for.

A parameter sets how many low-order bits of every adder are approximated. That covers the four pair adders and the four reduction adders. With the parameter at zero every addition is exact and the output is bit-exact. With a non-zero value each adder replaces the carry chain in its low bits with cheap logic, and the bits above stay exact. The multipliers are always exact. The error of the output therefore has a bound that can be computed from the coefficients.

Top module: `sfir_approx_top`

## Requirements
- R1: A rising clock edge with `rst_n` low clears `out_valid` and `out_sample` to 0 and empties the delay line, so outputs after reset see zero for every older sample.
- R2: A rising edge with `in_valid` high shifts `in_sample` into the newest tap (tap 0) and moves every tap one position older. With `in_valid` low the delay line is left unchanged and `in_sample` is ignored.
- R3: `out_valid` is high for one cycle, on the 4th rising edge after the edge that accepted a sample. Each accepted sample yields exactly one pulse, including for samples accepted on consecutive cycles.
- R4: `COEFS` packs five signed `COEF_W`-bit weights. h0 is at bits [15:0] and h4, the centre weight, is at bits [79:64]. Tap k, counted from the newest (k=0), is weighted by h_k for k≤4 and by h_(8-k) for k>4.
- R5: With `APPROX_BITS`=0, `out_sample` equals the exact sum over k of weight(k)·tap(k), bit for bit.
- R6: With `APPROX_BITS`=K>0, every adder forms its low K result bits as the bitwise OR of the operands. Its carry into bit K is the AND of both operands' bit K-1. The bits above K are added exactly. The error of each addition lies in (-2^(K-1), 2^(K-1)].
- R7: Multiplications are exact, so the output error is at most 2^(K-1)·(4+|h0|+|h1|+|h2|+|h3|). This approximation is visible, so on general data the output does differ from the exact value.
- R8: `out_sample` is a 35-bit two's-complement value and is exact for full-scale inputs of either sign, with no overflow.
- R9: `out_sample` holds its last value in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Accepts `in_sample` on this edge |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a new output |
| out_sample | output | 35 | Signed filtered sample |

## Verification
The delay line can shift in a new sample on the same edge that the pair-adder stage captures the line as it stood for the previous sample. An output pulse can also coincide with the acceptance of a fresh input. The bench provokes both cases with long runs of samples accepted on every cycle, mixed with gaps filled with junk values on an idle strobe. It judges them by requiring each pulse to arrive in the cycle predicted for its own sample and to carry the sum computed from the bench's own history at that sample. A second instance in approximate mode runs on the same stream, and its deviation is held to the computed bound.

// File: rtl/sfir_pkg.sv
// Package: structural constants of the symmetric order-8 filter.
// Assumes: even order, so taps split into ORDER/2 mirrored pairs plus a centre.
package sfir_pkg;
    localparam int ORDER = 8;
    localparam int NTAPS = ORDER + 1;
    localparam int NPAIR = ORDER / 2;
    localparam int NTERM = NPAIR + 1;
endpackage

// File: rtl/sfir_seg_adder.sv
// Module: sfir_seg_adder
// Adds two W-bit words. With K=0 the sum is exact. With K>0 the low K bits
// are the OR of the operands, the carry into bit K is predicted from bit K-1
// of both operands, and the upper W-K bits are added exactly.
// Assumes: 0 <= K <= W-2. Purely combinational.
module sfir_seg_adder #(
    parameter int W = 17,
    parameter int K = 0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    generate
        if (K == 0) begin : g_exact
            assign y = a + b;
        end else begin : g_apx
            localparam int HW = W - K;
            localparam longint HALF = 64'sd1 <<< (K - 1);
            logic [K-1:0]  lo;
            logic          cpred;
            logic [HW-1:0] hi;
            logic [W-1:0]  dev;

            // Low segment without carries, upper segment with predicted carry.
            always_comb begin
                lo    = a[K-1:0] | b[K-1:0];
                cpred = a[K-1] & b[K-1];
                hi    = a[W-1:K] + b[W-1:K] + HW'(cpred);
            end
            assign y   = {hi, lo};
            assign dev = y - (a + b);

            // Deviation of one approximate addition stays in its window (R6).
            always_comb begin
                if (!$isunknown({a, b})) begin
                    a_r6_err_bound: assert ((longint'($signed(dev)) <= HALF) &&
                                            (longint'($signed(dev)) > -HALF));
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sfir_tap_line.sv
// Module: sfir_tap_line
// Delay line of NTAPS signed samples. Tap 0 (lowest slice) is the newest.
// Shifts only when shift_en is high. Also registers the strobe as taps_vld.
// Assumes: synchronous active-low reset clears all taps.
module sfir_tap_line #(
    parameter int DATA_W = 16,
    parameter int NTAPS  = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift_en,
    input  logic [DATA_W-1:0]       din,
    output logic [NTAPS*DATA_W-1:0] taps,
    output logic                    taps_vld
);
    // Shift register advancing one tap per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps     <= '0;
            taps_vld <= 1'b0;
        end else begin
            taps_vld <= shift_en;
            if (shift_en) taps <= {taps[(NTAPS-1)*DATA_W-1:0], din};
        end
    end

    a_r2_newest_tap: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (taps[DATA_W-1:0] == $past(din)));
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(taps));
endmodule

// File: rtl/sfir_preadd.sv
// Module: sfir_preadd
// Sums each mirrored tap pair with a segmented adder and passes the centre tap
// through sign-extended. The results are registered with a valid flag.
// Assumes: NTAPS = 2*NPAIR+1; sums widen by one bit, so no overflow.
module sfir_preadd #(
    parameter int DATA_W = 16,
    parameter int NTAPS  = 9,
    parameter int NPAIR  = 4,
    parameter int K      = 0,
    localparam int SUM_W = DATA_W + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_vld,
    input  logic [NTAPS*DATA_W-1:0]       taps,
    output logic                          out_vld,
    output logic [(NPAIR+1)*SUM_W-1:0]    sums
);
    logic [(NPAIR+1)*SUM_W-1:0] sums_d;

    genvar p;
    generate
        for (p = 0; p < NPAIR; p++) begin : g_pair
            logic [SUM_W-1:0] newer, older;
            assign newer = {taps[p*DATA_W+DATA_W-1], taps[p*DATA_W +: DATA_W]};
            assign older = {taps[(NTAPS-1-p)*DATA_W+DATA_W-1],
                            taps[(NTAPS-1-p)*DATA_W +: DATA_W]};
            sfir_seg_adder #(.W(SUM_W), .K(K)) u_add (
                .a(newer), .b(older), .y(sums_d[p*SUM_W +: SUM_W]));
        end
    endgenerate
    assign sums_d[NPAIR*SUM_W +: SUM_W] =
        {taps[NPAIR*DATA_W+DATA_W-1], taps[NPAIR*DATA_W +: DATA_W]};

    // Capture the pair sums when a freshly shifted line is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            sums    <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) sums <= sums_d;
        end
    end
endmodule

// File: rtl/sfir_mult.sv
// Module: sfir_mult
// Multiplies each pair sum (and the centre) by its constant weight, exactly.
// Assumes: COEFS packs NTERM signed COEF_W-bit weights, term 0 lowest.
module sfir_mult #(
    parameter int SUM_W  = 17,
    parameter int COEF_W = 16,
    parameter int NTERM  = 5,
    parameter logic [NTERM*COEF_W-1:0] COEFS = '0,
    localparam int PROD_W = SUM_W + COEF_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_vld,
    input  logic [NTERM*SUM_W-1:0]    sums,
    output logic                      out_vld,
    output logic [NTERM*PROD_W-1:0]   prods
);
    genvar t;
    generate
        for (t = 0; t < NTERM; t++) begin : g_term
            logic signed [PROD_W-1:0] prod_d;
            assign prod_d = $signed(sums[t*SUM_W +: SUM_W]) *
                            $signed(COEFS[t*COEF_W +: COEF_W]);
            // Register one exact product per term.
            always_ff @(posedge clk) begin
                if (!rst_n) prods[t*PROD_W +: PROD_W] <= '0;
                else if (in_vld) prods[t*PROD_W +: PROD_W] <= prod_d;
            end
        end
    endgenerate

    // Forward the stage valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= in_vld;
    end
endmodule

// File: rtl/sfir_acc_tree.sv
// Module: sfir_acc_tree
// Reduces five products to one sum with four segmented adders over two
// registered levels: (p0+p1), (p2+p3) and p4, then ((a+b)+c).
// Assumes: NTERM = 5; ACC_W leaves two guard bits above PROD_W.
module sfir_acc_tree #(
    parameter int PROD_W = 33,
    parameter int ACC_W  = 35,
    parameter int NTERM  = 5,
    parameter int K      = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic [NTERM*PROD_W-1:0]  prods,
    output logic                     out_vld,
    output logic [ACC_W-1:0]         acc
);
    localparam int EXT = ACC_W - PROD_W;

    logic [NTERM-1:0][ACC_W-1:0] ext;
    logic [ACC_W-1:0] l1a_d, l1b_d, l1a, l1b, l1c, l2_mid, l2_d;
    logic             l1_vld;

    genvar t;
    generate
        for (t = 0; t < NTERM; t++) begin : g_ext
            assign ext[t] = {{EXT{prods[t*PROD_W+PROD_W-1]}}, prods[t*PROD_W +: PROD_W]};
        end
    endgenerate

    sfir_seg_adder #(.W(ACC_W), .K(K)) u_l1a (.a(ext[0]), .b(ext[1]), .y(l1a_d));
    sfir_seg_adder #(.W(ACC_W), .K(K)) u_l1b (.a(ext[2]), .b(ext[3]), .y(l1b_d));

    // First reduction level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l1_vld <= 1'b0;
            l1a <= '0; l1b <= '0; l1c <= '0;
        end else begin
            l1_vld <= in_vld;
            if (in_vld) begin
                l1a <= l1a_d; l1b <= l1b_d; l1c <= ext[4];
            end
        end
    end

    sfir_seg_adder #(.W(ACC_W), .K(K)) u_l2a (.a(l1a), .b(l1b), .y(l2_mid));
    sfir_seg_adder #(.W(ACC_W), .K(K)) u_l2b (.a(l2_mid), .b(l1c), .y(l2_d));

    // Final level: load the output only when a result is due, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            acc     <= '0;
        end else begin
            out_vld <= l1_vld;
            if (l1_vld) acc <= l2_d;
        end
    end
endmodule

// File: rtl/sfir_approx_top.sv
// Module: sfir_approx_top
// Streaming order-8 symmetric FIR: delay line, pair adders, exact weight
// multipliers, adder tree. APPROX_BITS sets the low bits of every adder that
// use carry-free logic (0 = exact). Latency: 4 edges after acceptance.
// Assumes: one channel; weights fixed at elaboration.
module sfir_approx_top
    import sfir_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int COEF_W      = 16,
    parameter int APPROX_BITS = 0,
    parameter logic [NTERM*COEF_W-1:0] COEFS =
        {16'd8191, 16'd5200, 16'd1650, 16'd310, 16'hFF88},
    localparam int SUM_W  = DATA_W + 1,
    localparam int PROD_W = SUM_W + COEF_W,
    localparam int ACC_W  = PROD_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_sample
);
    logic [NTAPS*DATA_W-1:0] taps;
    logic                    taps_vld, pre_vld, mul_vld;
    logic [NTERM*SUM_W-1:0]  sums;
    logic [NTERM*PROD_W-1:0] prods;

    sfir_tap_line #(.DATA_W(DATA_W), .NTAPS(NTAPS)) u_line (
        .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .din(in_sample),
        .taps(taps), .taps_vld(taps_vld));

    sfir_preadd #(.DATA_W(DATA_W), .NTAPS(NTAPS), .NPAIR(NPAIR), .K(APPROX_BITS)) u_pre (
        .clk(clk), .rst_n(rst_n), .in_vld(taps_vld), .taps(taps),
        .out_vld(pre_vld), .sums(sums));

    sfir_mult #(.SUM_W(SUM_W), .COEF_W(COEF_W), .NTERM(NTERM), .COEFS(COEFS)) u_mul (
        .clk(clk), .rst_n(rst_n), .in_vld(pre_vld), .sums(sums),
        .out_vld(mul_vld), .prods(prods));

    sfir_acc_tree #(.PROD_W(PROD_W), .ACC_W(ACC_W), .NTERM(NTERM), .K(APPROX_BITS)) u_tree (
        .clk(clk), .rst_n(rst_n), .in_vld(mul_vld), .prods(prods),
        .out_vld(out_valid), .acc(out_sample));

    // R3: one pulse per accepted sample, five registers downstream of the strobe.
    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3) &&
         $past(rst_n, 4) && $past(rst_n, 5)) |-> (out_valid == $past(in_valid, 5)));
    // R9: result register is quiet between pulses.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_sample));
    // R1: pulse cannot appear right after reset release.
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !out_valid);
endmodule

// File: tb/sim_sfir_approx_top.sv
`timescale 1ns/1ps
module sim_sfir_approx_top;
    localparam int  KA    = 4;
    localparam longint BOUND = (64'sd1 <<< (KA - 1)) * (4 + 120 + 310 + 1650 + 5200);
    localparam logic [79:0] CW = {16'd8191, 16'd5200, 16'd1650, 16'd310, 16'hFF88};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic out_valid0, out_valid1;
    logic [34:0] out_sample0, out_sample1;

    always #2.5 clk = ~clk;

    sfir_approx_top #(.APPROX_BITS(0), .COEFS(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid0), .out_sample(out_sample0));
    sfir_approx_top #(.APPROX_BITS(KA), .COEFS(CW)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid1), .out_sample(out_sample1));

    int     checks = 0, errors = 0, cyc = 0, wr = 0, rd = 0;
    int     hist[9];
    longint exp_q[4096];
    int     exp_cyc[4096];
    longint last0 = 0;
    bit     approx_differs = 0;

    function automatic longint weight(input int k);
        int j;
        j = (k > 4) ? 8 - k : k;
        case (j)
            0: return -120;
            1: return 310;
            2: return 1650;
            3: return 5200;
            default: return 8191;
        endcase
    endfunction

    function automatic longint model();
        longint s = 0;
        for (int k = 0; k < 9; k++) s += weight(k) * longint'(hist[k]);
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // R2: accept one sample and queue its expected result.
    task automatic push(input int s);
        @(negedge clk);
        for (int k = 8; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = s;
        in_valid = 1'b1;
        in_sample = 16'(s);
        exp_q[wr % 4096] = model();
        exp_cyc[wr % 4096] = cyc + 5;
        wr++;
    endtask

    // R2: idle cycles, optionally with junk on the ignored data input.
    task automatic idle(input int n, input bit junk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sample = junk ? 16'($urandom) : 16'h0;
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 100000) begin
            check(1'b0, "watchdog", cyc, 100000);
            report();
        end
    end

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(out_valid1 == out_valid0, "R3 pulse alignment of approximate instance",
                  out_valid1, out_valid0);
            if (out_valid0) begin
                if (rd == wr) begin
                    check(1'b0, "R3 pulse without accepted sample", rd, wr);
                end else begin
                    longint e, a0, a1, d;
                    e  = exp_q[rd % 4096];
                    a0 = longint'($signed(out_sample0));
                    a1 = longint'($signed(out_sample1));
                    d  = a1 - e;
                    check(cyc == exp_cyc[rd % 4096], "R3 output cycle", cyc, exp_cyc[rd % 4096]);
                    check(a0 == e, "R4 R5 exact output", a0, e);
                    check((d <= BOUND) && (d >= -BOUND), "R7 approximate error bound", d, BOUND);
                    if (d != 0) approx_differs = 1'b1;
                    rd++;
                end
                last0 = longint'($signed(out_sample0));
            end else begin
                check(longint'($signed(out_sample0)) == last0, "R9 hold between pulses",
                      longint'($signed(out_sample0)), last0);
            end
        end
    end

    initial begin
        for (int k = 0; k < 9; k++) hist[k] = 0;
        // R1: reset state.
        repeat (3) @(negedge clk);
        check(out_valid0 == 1'b0, "R1 out_valid in reset", out_valid0, 0);
        check(out_sample0 == '0, "R1 out_sample in reset", longint'($signed(out_sample0)), 0);
        check(out_sample1 == '0, "R1 approximate out_sample in reset",
              longint'($signed(out_sample1)), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: impulse back-to-back shows the symmetric weights.
        push(1);
        for (int i = 0; i < 9; i++) push(0);
        idle(8, 1'b0);

        // R2: impulse with junk on idle cycles in between.
        push(1000);
        for (int i = 0; i < 9; i++) begin
            idle(1 + (i % 3), 1'b1);
            push(0);
        end
        idle(8, 1'b1);

        // R8: full-scale runs of both signs.
        for (int i = 0; i < 12; i++) push(32767);
        for (int i = 0; i < 12; i++) push(-32768);
        for (int i = 0; i < 20; i++) push((i % 2) ? -32768 : 32767);
        idle(8, 1'b0);

        // R5 R6 R7: random data, random gaps with junk.
        for (int i = 0; i < 500; i++) begin
            push(int'($urandom % 65536) - 32768);
            if (($urandom % 4) == 0) idle(1 + int'($urandom % 3), 1'b1);
        end
        idle(10, 1'b1);

        // R1: mid-run reset forgets the history.
        for (int i = 0; i < 9; i++) push(12345 - i * 977);
        idle(8, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(out_valid0 == 1'b0, "R1 out_valid after mid-run reset", out_valid0, 0);
        check(out_sample0 == '0, "R1 out_sample after mid-run reset",
              longint'($signed(out_sample0)), 0);
        for (int k = 0; k < 9; k++) hist[k] = 0;
        last0 = 0;
        @(negedge clk);
        rst_n = 1'b1;
        push(-7);
        for (int i = 0; i < 9; i++) push(0);
        idle(10, 1'b0);

        check(rd == wr, "R3 one pulse per accepted sample", rd, wr);
        check(approx_differs, "R6 R7 approximation visible", approx_differs, 1);
        report();
    end
endmodule